// File: doc/BRIEF.md
# 32-bit ALU with Condition Flags

This block is a purely combinational arithmetic-logic unit for a 32-bit datapath. A 5-bit operation code chooses one of thirteen functions over two operands, `a_i` and `b_i`. The chosen result appears on `y_o`. Three condition flags appear alongside it: zero, negative and signed overflow. Every output follows the inputs in the same cycle, because the block holds no state.

A single adder/subtractor forms the flags for every operation. It subtracts when the code is SUB or one of the three compare codes, and it adds for every other code. The signed compare results are built from those same flags, so no second comparator is needed. The shifter is a logarithmic barrel. Left shifts reuse the right-shift stages by reversing the bit order on the way in and on the way out.

Top module: `alu_flags_core`

## Requirements
- R1: With op 0x00 (ADD), y_o equals (a_i + b_i) modulo 2^32.
- R2: With op 0x01 (SUB), y_o equals (a_i - b_i) modulo 2^32.
- R3: The flag path subtracts for ops 0x01, 0x05, 0x07 and 0x0D, and adds for every other op. z_o is 1 exactly when that 32-bit result is zero, and n_o equals its bit 31.
- R4: When the flag path adds, v_o is 1 only if the operands share a sign bit and the result's sign bit differs from it. When it subtracts, v_o is 1 only if the operands' sign bits differ and the result's sign bit differs from a_i's sign bit.
- R5: With op 0x02 (MUL), y_o equals the low 32 bits of a_i * b_i.
- R6: Ops 0x05 (equal), 0x07 (signed less-than) and 0x0D (signed less-or-equal) return 32'h1 when the condition holds and 32'h0 when it does not.
- R7: Ops 0x08 (shift left, zero fill), 0x09 (logical right shift) and 0x0B (arithmetic right shift, copying bit 31) shift a_i by b_i[4:0]. Bits b_i[31:5] have no effect.
- R8: Ops 0x18, 0x1E and 0x06 return a_i AND b_i, a_i OR b_i and a_i XOR b_i.
- R9: With op 0x0A, y_o equals a_i.
- R10: Any op not listed above drives y_o to zero. The flags still follow the add path in that case.
- R11: The block is combinational. All outputs are valid in the same cycle the inputs are applied, and earlier inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits [4:0] are the shift amount |
| y_o | output | 32 | Result |
| z_o | output | 1 | Flag-path result is zero |
| n_o | output | 1 | Bit 31 of the flag-path result |
| v_o | output | 1 | Signed overflow of the flag path |

## Verification
Every result and every flag is due zero cycles after the inputs change, because no register lies anywhere in the path. The bench applies each vector just after a rising clock edge and samples all four outputs at the following falling edge. This leaves half a period for the logic to settle, and the sampling never depends on how processes are ordered at the edge. Back-to-back vectors with different ops show that the previous vector leaves no trace in the outputs.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'h00,
    OP_SUB  = 5'h01,
    OP_MUL  = 5'h02,
    OP_CEQ  = 5'h05,
    OP_XOR  = 5'h06,
    OP_CLT  = 5'h07,
    OP_SLL  = 5'h08,
    OP_SRL  = 5'h09,
    OP_PASS = 5'h0A,
    OP_SRA  = 5'h0B,
    OP_CLE  = 5'h0D,
    OP_AND  = 5'h18,
    OP_OR   = 5'h1E
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic                       sub_i,
  input  logic [WIDTH-1:0]           a_i,
  input  logic [WIDTH-1:0]           b_i,
  output logic [WIDTH-1:0]           sum_o,
  output alu_flags_pkg::alu_flags_t  flags_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff     = sub_i ? ~b_i : b_i;
    sum_o     = a_i + b_eff + WIDTH'(sub_i);
    flags_o.z = (sum_o == '0);
    flags_o.n = sum_o[MSB];
    // same-sign inputs to the adder, result sign flipped
    flags_o.v = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]         a_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  input  logic                     left_i,
  input  logic                     arith_i,
  output logic [WIDTH-1:0]         y_o
);
  localparam int unsigned STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] a_rev, res_rev, src;
  logic [WIDTH-1:0] st [STAGES+1];
  logic             fill;

  // bit reversal lets left shifts reuse the right-shift stages
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign a_rev[i]   = a_i[WIDTH-1-i];
    assign res_rev[i] = st[STAGES][WIDTH-1-i];
  end

  assign src   = left_i ? a_rev : a_i;
  assign fill  = arith_i & ~left_i & a_i[WIDTH-1];
  assign st[0] = src;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    assign st[k+1] = amt_i[k] ? {{SH{fill}}, st[k][WIDTH-1:SH]} : st[k];
  end

  assign y_o = left_i ? res_rev : st[STAGES];
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int unsigned WIDTH = 32
) (
  input  alu_flags_pkg::alu_op_e     op_i,
  input  alu_flags_pkg::alu_flags_t  flags_i,
  output logic [WIDTH-1:0]           y_o
);
  import alu_flags_pkg::*;

  logic hit;

  // flags come from a - b here
  always_comb begin
    unique case (op_i)
      OP_CEQ:  hit = flags_i.z;
      OP_CLT:  hit = flags_i.n ^ flags_i.v;
      OP_CLE:  hit = (flags_i.n ^ flags_i.v) | flags_i.z;
      default: hit = 1'b0;
    endcase
    y_o = WIDTH'(hit);
  end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o,
  output logic             z_o,
  output logic             n_o,
  output logic             v_o
);
  import alu_flags_pkg::*;

  localparam int unsigned SHW = $clog2(WIDTH);

  alu_op_e          op;
  logic             use_sub;
  logic [WIDTH-1:0] sum, sh_res, cmp_res, mul_res;
  alu_flags_t       flags;

  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_SUB, OP_CEQ, OP_CLT, OP_CLE: use_sub = 1'b1;
      default:                        use_sub = 1'b0;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .sub_i   (use_sub),
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (sum),
    .flags_o (flags)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .a_i     (a_i),
    .amt_i   (b_i[SHW-1:0]),
    .left_i  (op == OP_SLL),
    .arith_i (op == OP_SRA),
    .y_o     (sh_res)
  );

  alu_compare #(.WIDTH(WIDTH)) u_cmp (
    .op_i    (op),
    .flags_i (flags),
    .y_o     (cmp_res)
  );

  assign mul_res = a_i * b_i;

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:           y_o = sum;
      OP_MUL:                   y_o = mul_res;
      OP_CEQ, OP_CLT, OP_CLE:   y_o = cmp_res;
      OP_SLL, OP_SRL, OP_SRA:   y_o = sh_res;
      OP_AND:                   y_o = a_i & b_i;
      OP_OR:                    y_o = a_i | b_i;
      OP_XOR:                   y_o = a_i ^ b_i;
      OP_PASS:                  y_o = a_i;
      default:                  y_o = '0;
    endcase
  end

  assign z_o = flags.z;
  assign n_o = flags.n;
  assign v_o = flags.v;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [4:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] y_o,
  input logic             z_o,
  input logic             n_o,
  input logic             v_o
);
  localparam int unsigned SHW = $clog2(WIDTH);

  always_comb begin
    if (op_i == 5'h00) begin
      assert_add_zero_R3: assert (z_o == (y_o == '0));
      assert_add_neg_R3: assert (n_o == y_o[WIDTH-1]);
      assert_add_ovf_R4: assert (v_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (y_o[WIDTH-1] != a_i[WIDTH-1])));
    end
    if (op_i == 5'h07) begin
      assert_cmp_lt_R6: assert (y_o == WIDTH'($signed(a_i) < $signed(b_i)));
    end
    if (op_i == 5'h0D) begin
      assert_cmp_le_R6: assert (y_o == WIDTH'($signed(a_i) <= $signed(b_i)));
    end
    if (op_i == 5'h09) begin
      assert_srl_R7: assert (y_o == (a_i >> b_i[SHW-1:0]));
    end
    if (op_i == 5'h0A) begin
      assert_pass_R9: assert (y_o == a_i);
    end
    if (op_i inside {5'h03, 5'h04, 5'h0C, 5'h0E, 5'h0F, 5'h10, 5'h1F}) begin
      assert_undef_zero_R10: assert (y_o == '0);
    end
  end
endmodule

bind alu_flags_core alu_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_flags_core_tb_top.sv
module alu_flags_core_tb_top;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [4:0]   op;
  logic [W-1:0] a, b, y;
  logic         z, n, v;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  alu_flags_core #(.WIDTH(W)) dut_i (
    .op_i (op), .a_i (a), .b_i (b),
    .y_o (y), .z_o (z), .n_o (n), .v_o (v)
  );

  function automatic logic [W-1:0] ref_y(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] q);
    case (o)
      5'h00: return x + q;
      5'h01: return x - q;
      5'h02: return x * q;
      5'h05: return W'(x == q);
      5'h07: return W'($signed(x) < $signed(q));
      5'h0D: return W'($signed(x) <= $signed(q));
      5'h08: return x << q[4:0];
      5'h09: return x >> q[4:0];
      5'h0B: return W'($signed(x) >>> q[4:0]);
      5'h0A: return x;
      5'h18: return x & q;
      5'h1E: return x | q;
      5'h06: return x ^ q;
      default: return '0;
    endcase
  endfunction

  // flags: signed 33-bit reference, out-of-range means overflow
  function automatic logic [2:0] ref_f(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] q);
    logic sub;
    longint s;
    logic [W-1:0] r;
    sub = (o inside {5'h01, 5'h05, 5'h07, 5'h0D});
    s = sub ? (longint'($signed(x)) - longint'($signed(q)))
            : (longint'($signed(x)) + longint'($signed(q)));
    r = W'(s);
    return {r == '0, r[W-1], (s > 64'sh7FFFFFFF) || (s < -64'sh80000000)};
  endfunction

  function automatic string req_of(input logic [4:0] o);
    case (o)
      5'h00: return "R1";
      5'h01: return "R2";
      5'h02: return "R5";
      5'h05, 5'h07, 5'h0D: return "R6";
      5'h08, 5'h09, 5'h0B: return "R7";
      5'h18, 5'h1E, 5'h06: return "R8";
      5'h0A: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h act=%h exp=%h", req, op, a, b, act, exp);
    end
  endtask

  // apply after posedge, sample at negedge (R11: zero-cycle latency)
  task automatic apply(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] q);
    logic [2:0] f;
    @(posedge clk);
    #0.5;
    op = o; a = x; b = q;
    @(negedge clk);
    f = ref_f(o, x, q);
    check(req_of(o), y, ref_y(o, x, q));
    check("R3", W'(z), W'(f[2]));
    check("R3", W'(n), W'(f[1]));
    check("R4", W'(v), W'(f[0]));
  endtask

  initial begin
    logic [4:0] codes [13];
    codes = '{5'h00, 5'h01, 5'h02, 5'h05, 5'h06, 5'h07, 5'h08,
              5'h09, 5'h0A, 5'h0B, 5'h0D, 5'h18, 5'h1E};
    op = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state, all-zero inputs (R1, R3, R11)
    check("R1", y, '0);
    check("R3", W'(z), 1);

    // adder patterns: alternating bits, all ones, wrap (R1 R2 R3 R4)
    apply(5'h00, 32'h5555_5555, 32'h5555_5555);
    apply(5'h00, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
    apply(5'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply(5'h00, 32'h0000_0001, 32'hFFFF_FFFF);
    apply(5'h00, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(5'h01, 32'h8000_0000, 32'h0000_0001);
    apply(5'h01, 32'h0000_007F, 32'hFFFF_FFFF);
    apply(5'h01, 32'h0000_0000, 32'h8000_0000);
    apply(5'h01, 32'hFFFF_FFF2, 32'hFFFF_FFF0);
    // compares at signed boundaries (R6)
    apply(5'h07, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(5'h07, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(5'h0D, 32'h1234_5678, 32'h1234_5678);
    apply(5'h05, 32'h1234_5678, 32'h1234_5678);
    apply(5'h05, 32'h1234_5678, 32'h1234_5679);
    // shifts, upper bits of b ignored (R7)
    apply(5'h08, 32'h8000_0001, 32'hFFFF_FFE1);
    apply(5'h09, 32'h8000_0000, 32'h0000_001F);
    apply(5'h0B, 32'h8000_0000, 32'h0000_001F);
    apply(5'h0B, 32'hF0F0_0000, 32'h1234_5664);
    apply(5'h09, 32'hDEAD_BEEF, 32'h0000_0000);
    // MUL, logic, pass, undefined codes (R5 R8 R9 R10)
    apply(5'h02, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply(5'h18, 32'hAAAA_AAAA, 32'hFFFF_0000);
    apply(5'h1E, 32'hAAAA_AAAA, 32'h5555_5555);
    apply(5'h06, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
    apply(5'h0A, 32'hCAFE_F00D, 32'h1111_1111);
    apply(5'h03, 32'hFFFF_FFFF, 32'h0000_0001);
    apply(5'h1F, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    apply(5'h0C, 32'h8000_0000, 32'h8000_0000);

    // random mix (R11: successive vectors independent)
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] o;
      o = ($urandom % 4 == 0) ? 5'($urandom) : codes[$urandom % 13];
      apply(o, $urandom, ($urandom % 3 == 0) ? W'($urandom % 40) : W'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule